// File: doc/BRIEF.md
# Threshold-Gated Sleep Entry Controller

This block decides when a sensing device may drop into its low-power sleep state. Firmware first programs an 8-bit mode register. Three bits of that register pick one of seven wake thresholds; the remaining bits hold control settings. Firmware then issues one of two commands: a plain power-down, or a calibrate-then-power-down. The block arms on either command. It then compares the magnitude of a signed, digitised sense sample against the selected threshold. It enters sleep only once that magnitude is strictly below the threshold.

A threshold select of zero skips the comparison, so the device sleeps at once. A request whose condition is not yet met stays armed. The block watches each following sample and sleeps as soon as one falls below the threshold. Sleep is held until the wake input is pulsed. A wake pulse also cancels an armed request that has not yet reached sleep.

Top module: `sleep_gate_ctrl`

## Requirements
- R1: After reset, `mode_rd` reads 0x0E (select field all ones, every other bit zero) and `sleep` is 0.
- R2: A write with `wr_en` high and `wr_addr` equal to 0x64 loads `wr_data` into the mode register, with bit 0 forced to 0. Writes to any other address leave the register unchanged. `mode_rd` shows the stored value from the cycle after the write, and its bit 0 always reads 0.
- R3: The sense magnitude saturates. The most negative sample (-2048 for a 12-bit sample) gives 2047 and never wraps to a small value. With a nonzero select, such a sample never lets the block sleep.
- R4: When a command arrives in the awake state with a nonzero select and the magnitude below the threshold, `sleep` is 1 in the next cycle.
- R5: If the magnitude is equal to or above the threshold, the request stays armed and `sleep` stays 0. `sleep` rises only in the cycle after a cycle in which the block was armed or received a command, and in which the magnitude was below the threshold.
- R6: With select field `mode_rd[3:1]` equal to 000, a command leads to sleep in the next cycle, whatever the sample.
- R7: `cmd_code` 01 (power-down) and 10 (calibrate-then-power-down) both arm the block. Codes 00 and 11 with `cmd_valid` high are ignored.
- R8: A cycle with `wake` high leaves `sleep` 0 and the request disarmed in the next cycle. Wake takes priority over a command in the same cycle.
- R9: While asleep, commands have no effect and `sleep` stays 1 until `wake`.
- R10: Select codes 1 to 7 use the thresholds 16, 32, 64, 128, 256, 512 and 1024 in that order, by default. The comparison is strict and applies to both signs of the sample.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 8 | Register write address |
| wr_data | input | 8 | Register write data |
| cmd_valid | input | 1 | Command strobe |
| cmd_code | input | 2 | Command: 01 power-down, 10 calibrate-then-power-down |
| sense_sample | input | 12 | Signed two's-complement sense sample |
| wake | input | 1 | Wake pulse; exits sleep and cancels an armed request |
| sleep | output | 1 | High while in sleep |
| mode_rd | output | 8 | Mode register read-back |

## Verification
The bench drives the most negative sample with the smallest threshold selected. A magnitude that wraps instead of saturating would read as zero and put the device to sleep. Samples exactly at a threshold and one below it, on both signs, expose a non-strict compare and a wrong entry in the threshold table. Wake in the same cycle as a command, and commands while asleep, catch a wrong priority and any re-arming during sleep. A zero select with a full-scale sample checks the forced path. Writes to a neighbouring address, and writes with bit 0 set, check address decode and the reserved bit.

// File: rtl/sgc_pkg.sv
package sgc_pkg;

  typedef enum logic [1:0] {
    CMD_NONE  = 2'b00,
    CMD_PDOWN = 2'b01,
    CMD_CALPD = 2'b10,
    CMD_RSVD  = 2'b11
  } cmd_e;

  typedef enum logic [1:0] {
    ST_AWAKE = 2'b00,
    ST_ARMED = 2'b01,
    ST_SLEEP = 2'b10
  } slp_state_e;

  localparam int SEL_LSB = 1;
  localparam int SEL_W   = 3;
  localparam int NUM_THR = (1 << SEL_W) - 1;

  localparam logic [7:0] MODE_RST = 8'h0E;

endpackage

// File: rtl/sgc_mode_reg.sv
module sgc_mode_reg
  import sgc_pkg::*;
#(
  parameter logic [7:0] REG_ADDR = 8'h64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [7:0]       wr_addr,
  input  logic [7:0]       wr_data,
  output logic [7:0]       mode_q,
  output logic [SEL_W-1:0] sel
);

  logic       hit;
  logic [7:0] mode_d;

  assign hit = wr_en && (wr_addr == REG_ADDR);

  always_comb begin
    mode_d = mode_q;
    if (hit) begin
      mode_d = {wr_data[7:1], 1'b0};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= MODE_RST;
    end else if (hit) begin
      mode_q <= mode_d;
    end
  end

  assign sel = mode_q[SEL_LSB +: SEL_W];

endmodule

// File: rtl/sgc_abs_sat.sv
module sgc_abs_sat #(
  parameter int W = 12
) (
  input  logic [W-1:0] din,
  output logic [W-2:0] mag
);

  logic         is_min;
  logic [W-1:0] neg;

  assign is_min = din[W-1] & ~(|din[W-2:0]);
  assign neg    = ~din + {{(W-1){1'b0}}, 1'b1};

  always_comb begin
    if (is_min) begin
      mag = {(W-1){1'b1}};
    end else if (din[W-1]) begin
      mag = neg[W-2:0];
    end else begin
      mag = din[W-2:0];
    end
  end

endmodule

// File: rtl/sgc_thr_cmp.sv
module sgc_thr_cmp
  import sgc_pkg::*;
#(
  parameter int          MAG_W = 11,
  parameter int unsigned THR_TAB [NUM_THR] = '{16, 32, 64, 128, 256, 512, 1024}
) (
  input  logic [SEL_W-1:0] sel,
  input  logic [MAG_W-1:0] mag,
  output logic             cond_ok
);

  logic [MAG_W-1:0] thr_vec [NUM_THR+1];
  logic [MAG_W-1:0] thr;
  logic             forced;

  assign thr_vec[0] = '0;

  for (genvar k = 1; k <= NUM_THR; k++) begin : g_thr
    assign thr_vec[k] = MAG_W'(THR_TAB[k-1]);
  end

  assign thr     = thr_vec[sel];
  assign forced  = (sel == '0);
  assign cond_ok = forced || (mag < thr);

endmodule

// File: rtl/sgc_fsm.sv
module sgc_fsm
  import sgc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cmd_valid,
  input  logic [1:0] cmd_code,
  input  logic       wake,
  input  logic       cond_ok,
  output logic       sleep,
  output logic       armed,
  output logic       cmd_ok
);

  slp_state_e st_q, st_d;

  assign cmd_ok = cmd_valid &&
                  ((cmd_code == CMD_PDOWN) || (cmd_code == CMD_CALPD));

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_AWAKE: begin
        if (!wake && cmd_ok) begin
          st_d = cond_ok ? ST_SLEEP : ST_ARMED;
        end
      end
      ST_ARMED: begin
        if (wake) begin
          st_d = ST_AWAKE;
        end else if (cond_ok) begin
          st_d = ST_SLEEP;
        end
      end
      ST_SLEEP: begin
        if (wake) begin
          st_d = ST_AWAKE;
        end
      end
      default: st_d = ST_AWAKE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= ST_AWAKE;
    end else begin
      st_q <= st_d;
    end
  end

  assign sleep = (st_q == ST_SLEEP);
  assign armed = (st_q == ST_ARMED);

endmodule

// File: rtl/sleep_gate_ctrl.sv
module sleep_gate_ctrl
  import sgc_pkg::*;
#(
  parameter int          SAMPLE_W = 12,
  parameter logic [7:0]  REG_ADDR = 8'h64,
  parameter int unsigned THR_TAB [NUM_THR] = '{16, 32, 64, 128, 256, 512, 1024}
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [7:0]          wr_addr,
  input  logic [7:0]          wr_data,
  input  logic                cmd_valid,
  input  logic [1:0]          cmd_code,
  input  logic [SAMPLE_W-1:0] sense_sample,
  input  logic                wake,
  output logic                sleep,
  output logic [7:0]          mode_rd
);

  localparam int MAG_W = SAMPLE_W - 1;

  logic [1:0]       rst_sync_q;
  logic             rst_core_n;
  logic [SEL_W-1:0] sel;
  logic [MAG_W-1:0] mag;
  logic             cond_ok;
  logic             armed;
  logic             cmd_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= 2'b00;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end

  assign rst_core_n = rst_sync_q[1];

  sgc_mode_reg #(.REG_ADDR(REG_ADDR)) u_mode (
    .clk     (clk),
    .rst_n   (rst_core_n),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .mode_q  (mode_rd),
    .sel     (sel)
  );

  sgc_abs_sat #(.W(SAMPLE_W)) u_abs (
    .din (sense_sample),
    .mag (mag)
  );

  sgc_thr_cmp #(.MAG_W(MAG_W), .THR_TAB(THR_TAB)) u_cmp (
    .sel     (sel),
    .mag     (mag),
    .cond_ok (cond_ok)
  );

  sgc_fsm u_fsm (
    .clk       (clk),
    .rst_n     (rst_core_n),
    .cmd_valid (cmd_valid),
    .cmd_code  (cmd_code),
    .wake      (wake),
    .cond_ok   (cond_ok),
    .sleep     (sleep),
    .armed     (armed),
    .cmd_ok    (cmd_ok)
  );

endmodule

// File: rtl/sleep_gate_chk.sv
module sleep_gate_chk #(
  parameter int SAMPLE_W = 12
) (
  input logic                clk,
  input logic                rst_core_n,
  input logic                sleep,
  input logic                armed,
  input logic                cmd_ok,
  input logic                wake,
  input logic [7:0]          mode_rd,
  input logic [SAMPLE_W-1:0] sense_sample
);

  localparam logic [SAMPLE_W-1:0] MOST_NEG = {1'b1, {(SAMPLE_W-1){1'b0}}};

  assert_bit0_zero_R2: assert property (@(posedge clk) disable iff (!rst_core_n)
    mode_rd[0] == 1'b0);

  assert_sat_no_sleep_R3: assert property (@(posedge clk) disable iff (!rst_core_n)
    (!sleep && !wake && mode_rd[3:1] != 3'b000 && sense_sample == MOST_NEG) |=> !sleep);

  assert_entry_cause_R5: assert property (@(posedge clk) disable iff (!rst_core_n)
    $rose(sleep) |-> $past(armed || cmd_ok));

  assert_forced_R6: assert property (@(posedge clk) disable iff (!rst_core_n)
    (!sleep && !wake && cmd_ok && mode_rd[3:1] == 3'b000) |=> sleep);

  assert_wake_exit_R8: assert property (@(posedge clk) disable iff (!rst_core_n)
    wake |=> (!sleep && !armed));

  assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_core_n)
    (sleep && !wake) |=> sleep);

endmodule

bind sleep_gate_ctrl sleep_gate_chk #(.SAMPLE_W(SAMPLE_W)) u_chk (
  .clk          (clk),
  .rst_core_n   (rst_core_n),
  .sleep        (sleep),
  .armed        (armed),
  .cmd_ok       (cmd_ok),
  .wake         (wake),
  .mode_rd      (mode_rd),
  .sense_sample (sense_sample)
);

// File: tb/tb_sleep_gate_ctrl.sv
`timescale 1ns/1ps
module tb_sleep_gate_ctrl;

  logic        clk;
  logic        rst_n;
  logic        wr_en;
  logic [7:0]  wr_addr;
  logic [7:0]  wr_data;
  logic        cmd_valid;
  logic [1:0]  cmd_code;
  logic [11:0] sense_sample;
  logic        wake;
  logic        sleep;
  logic [7:0]  mode_rd;

  int total = 0;
  int bad = 0;
  bit cmp_en = 0;
  bit done = 0;
  string phase = "R1";

  // reference model state
  int m_mode;
  int m_st; // 0 awake, 1 armed, 2 asleep

  sleep_gate_ctrl dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .cmd_valid(cmd_valid), .cmd_code(cmd_code),
    .sense_sample(sense_sample), .wake(wake), .sleep(sleep), .mode_rd(mode_rd)
  );

  initial clk = 0;
  always #10 clk = ~clk;

  function automatic int thr_of(int s);
    int t [8] = '{0, 16, 32, 64, 128, 256, 512, 1024};
    return t[s];
  endfunction

  function automatic bit cond_of(int mode, logic [11:0] smp);
    int v;
    int sel;
    v = $signed(smp);
    if (v < 0) v = -v;
    if (v > 2047) v = 2047;
    sel = (mode >> 1) & 7;
    if (sel == 0) return 1;
    return v < thr_of(sel);
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_mode <= 'h0E;
      m_st   <= 0;
    end else begin
      bit c;
      bit ok;
      c  = cond_of(m_mode, sense_sample);
      ok = cmd_valid && (cmd_code == 2'b01 || cmd_code == 2'b10);
      if (wr_en && wr_addr == 8'h64) m_mode <= wr_data & 8'hFE;
      case (m_st)
        0: if (!wake && ok) m_st <= c ? 2 : 1;
        1: if (wake) m_st <= 0; else if (c) m_st <= 2;
        default: if (wake) m_st <= 0;
      endcase
    end
  end

  task automatic chk(string tag, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (cmp_en && !done) begin
      chk({phase, " model sleep"}, sleep, (m_st == 2));
      chk({phase, " model mode"}, mode_rd, m_mode);
    end
  end

  task automatic wr(logic [7:0] a, logic [7:0] d);
    wr_en = 1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic cmd(logic [1:0] c);
    cmd_valid = 1; cmd_code = c;
    @(negedge clk);
    cmd_valid = 0; cmd_code = 2'b00;
  endtask

  task automatic do_wake();
    wake = 1;
    @(negedge clk);
    wake = 0;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    rst_n = 0; wr_en = 0; wr_addr = 0; wr_data = 0;
    cmd_valid = 0; cmd_code = 0; sense_sample = 0; wake = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    idle(3);
    cmp_en = 1;

    phase = "R1";
    chk("R1 reset mode", mode_rd, 8'h0E);
    chk("R1 reset sleep", sleep, 0);

    phase = "R2";
    wr(8'h64, 8'hFF);
    chk("R2 write bit0 cleared", mode_rd, 8'hFE);
    wr(8'h65, 8'h00);
    chk("R2 other address ignored", mode_rd, 8'hFE);

    phase = "R3";
    wr(8'h64, 8'h02);                 // select 1, threshold 16
    sense_sample = 12'h800;           // -2048
    cmd(2'b01);
    chk("R3 most negative no sleep", sleep, 0);
    idle(3);
    chk("R3 stays armed awake", sleep, 0);

    phase = "R5";
    sense_sample = 12'd16;
    idle(1);
    chk("R5 equal threshold no sleep", sleep, 0);
    sense_sample = 12'd15;
    idle(1);
    chk("R5 armed then below sleeps", sleep, 1);

    phase = "R8";
    do_wake();
    chk("R8 wake exits sleep", sleep, 0);

    phase = "R10";
    wr(8'h64, 8'h0E);                 // select 7, threshold 1024
    sense_sample = 12'd1023;
    cmd(2'b10);
    chk("R4 R10 below top threshold sleeps", sleep, 1);
    do_wake();
    sense_sample = 12'd1024;
    cmd(2'b01);
    chk("R10 at top threshold stays awake", sleep, 0);

    phase = "R8";
    do_wake();
    sense_sample = 12'd0;
    idle(2);
    chk("R8 wake cancels armed request", sleep, 0);

    phase = "R6";
    wr(8'h64, 8'hC0);                 // select 0
    sense_sample = 12'h800;
    cmd(2'b10);
    chk("R6 R7 forced sleep", sleep, 1);

    phase = "R9";
    cmd(2'b01);
    chk("R9 command while asleep", sleep, 1);
    idle(3);
    chk("R9 held asleep", sleep, 1);

    phase = "R8";
    wake = 1; cmd_valid = 1; cmd_code = 2'b01;
    @(negedge clk);
    wake = 0; cmd_valid = 0; cmd_code = 0;
    chk("R8 wake beats command", sleep, 0);
    idle(2);
    chk("R8 no later sleep", sleep, 0);

    phase = "R7";
    cmd(2'b11);
    chk("R7 reserved code ignored", sleep, 0);
    cmd(2'b00);
    chk("R7 none code ignored", sleep, 0);

    phase = "R10";
    wr(8'h64, 8'h02);
    sense_sample = -12'sd16;
    cmd(2'b01);
    chk("R10 negative at threshold awake", sleep, 0);
    do_wake();
    sense_sample = -12'sd15;
    cmd(2'b01);
    chk("R4 R10 negative below sleeps", sleep, 1);
    do_wake();
    wr(8'h64, 8'h08);                 // select 4, threshold 128
    sense_sample = 12'd127;
    cmd(2'b01);
    chk("R10 select 4 below sleeps", sleep, 1);
    do_wake();
    idle(2);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      total++;
      bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule